// File: doc/BRIEF.md
# Bus-Master ADC Polling Sequencer

This block runs measurements on an analog-to-digital converter that it does not own. It reaches the converter and a sensor multiplexer only through single write and read transactions on a small memory-mapped master port. Every address it touches, and every value it writes, comes from a configuration register. A round visits each enabled sensing point in turn. For each point it selects the sensor, starts a conversion, polls until the converter flags valid data, and then stores a 12-bit sample in that point's result register.

A free-running pacer starts a new round at a fixed period set in units of 256 clock cycles. When polling for a point drags on past a programmed limit, the block emits a one-cycle timeout pulse and moves to the next point. Software sets up the block and reads the results through a simple slave register port.

Top module: `adc_poll_seq`

## Requirements
- R1: After reset, no master request is raised, the timeout pulse is low, and all four result registers read 0.
- R2: Rounds start every UNIT*256*SENSE clock cycles, where UNIT is bits [15:0] of word 1 and SENSE is bits [15:0] of word 2. A zero in either one stops the pacer and clears its counters, and no round starts while it is zero.
- R3: A round visits, in ascending index order, only the points whose bit is set in the point mask (word 0, bits [3:0]). The write-control word (word 5) selects the writes made for each point, which follow this order: bit 0 enables the sensor-select write (address word 6, value word 20+point); bit 1 enables the mux write (address word 7, value word 8); bit 2 enables extra write A (words 9/10); bit 3 enables extra write B (words 11/12). The conversion-start write (address word 13, value word 14) always comes last.
- R4: After the start write, the block reads the valid address (word 15). Bits [4:0] of word 18 give the position of the valid flag in the read word. Bit 5 of word 18 set means the flag is active-high; clear means it is active-low.
- R5: When word 17 is zero, the sample comes from the same word that carried the valid flag. When word 17 is non-zero, the block makes one more read at the voltage address (word 16) and takes the sample from that.
- R6: The stored sample is the low 12 bits of the sample word shifted right by word 19 bits [4:0].
- R7: After a poll that finds no valid flag, the request stays low for POLL_GAP+1 cycles (POLL_GAP is word 3, bits [15:0]) before the next poll.
- R8: When POLL_LIMIT+1 polls of one point all fail (POLL_LIMIT is word 4, bits [15:0]), the block raises the timeout output for exactly one cycle. That point's result keeps its previous value, and the round continues with the next enabled point.
- R9: The result registers read back at words 24 to 27 for points 0 to 3, zero-extended. Writes to those words are ignored.
- R10: The master port has at most one transaction in flight. Once raised, the request holds its direction, address and write data until the cycle in which it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (combinational) |
| m_req | output | 1 | Master transaction request |
| m_we | output | 1 | Master write (1) or read (0) |
| m_addr | output | 32 | Master transaction address |
| m_wdata | output | 32 | Master write data |
| m_ack | input | 1 | Transaction acknowledge from the target |
| m_rdata | input | 32 | Read data, valid with m_ack |
| timeout_evt | output | 1 | One-cycle pulse when a point's polling times out |

## Verification
Several properties are checked on every cycle. The request must stay stable until it is acknowledged. Every read must target the valid address or the voltage address. Every write must target one of the five programmed write addresses. A voltage-address read may only happen in split-read mode. The timeout pulse must last a single cycle and must follow a read acknowledge. Other behaviours only show up in the bench scenarios: the exact transaction order per point for a given mask and write-control word, the flag polarity, the shift and 12-bit extraction, the poll spacing, the round period, and the fact that results are kept after a timeout.

// File: rtl/adcps_pkg.sv
package adcps_pkg;
  localparam int NPTS     = 4;
  localparam int PT_W     = $clog2(NPTS);
  localparam int IDX_W    = PT_W + 1;
  localparam int DW       = 32;
  localparam int AW       = 32;
  localparam int RES_W    = 12;
  localparam int CW       = 16;
  localparam int PRE_W    = CW + 8;
  localparam int NWR      = 4;
  localparam int REG_AW   = 5;
  localparam int NREG     = 20 + NPTS;
  localparam int RES_BASE = NREG;

  // configuration word indices
  localparam int W_MASK = 0,  W_UNIT = 1,  W_SENSE = 2, W_GAP = 3,  W_LIMIT = 4;
  localparam int W_WCTL = 5,  W_SELA = 6,  W_MUXA = 7,  W_MUXV = 8, W_XAA = 9;
  localparam int W_XAV  = 10, W_XBA = 11,  W_XBV = 12,  W_ENA = 13, W_ENV = 14;
  localparam int W_VLDA = 15, W_VOLA = 16, W_SPLIT = 17, W_VSEL = 18, W_SHIFT = 19;
  localparam int W_SELV = 20;

  typedef struct packed {
    logic [NPTS-1:0]          pt_mask;
    logic [CW-1:0]            unit;
    logic [CW-1:0]            sense;
    logic [CW-1:0]            gap;
    logic [CW-1:0]            limit;
    logic [NWR-1:0]           wctl;
    logic [AW-1:0]            sel_addr;
    logic [AW-1:0]            mux_addr;
    logic [DW-1:0]            mux_val;
    logic [AW-1:0]            xa_addr;
    logic [DW-1:0]            xa_val;
    logic [AW-1:0]            xb_addr;
    logic [DW-1:0]            xb_val;
    logic [AW-1:0]            en_addr;
    logic [DW-1:0]            en_val;
    logic [AW-1:0]            vld_addr;
    logic [AW-1:0]            volt_addr;
    logic                     split;
    logic [5:0]               vsel;
    logic [4:0]               shift;
    logic [NPTS-1:0][DW-1:0]  sel_val;
  } cfg_t;

  typedef enum logic [3:0] {
    S_IDLE, S_NEXT, S_SEL, S_MUX, S_XA, S_XB, S_EN, S_POLL, S_GAP, S_VOLT
  } seq_st_t;
endpackage

// File: rtl/adcps_regs.sv
module adcps_regs
  import adcps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  input  logic              res_we,
  input  logic [PT_W-1:0]   res_idx,
  input  logic [RES_W-1:0]  res_val,
  output cfg_t              cfg
);
  logic [DW-1:0]    mem_q [NREG];
  logic [RES_W-1:0] res_q [NPTS];
  logic             wr_en;
  logic [REG_AW-1:0] roff;

  assign wr_en = cfg_we && (cfg_addr < REG_AW'(NREG));
  assign roff  = cfg_addr - REG_AW'(RES_BASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[cfg_addr] <= cfg_wdata;
    end
  end

  for (genvar g = 0; g < NPTS; g++) begin : g_res
    logic res_en;
    assign res_en = res_we && (res_idx == PT_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      res_q[g] <= '0;
      else if (res_en) res_q[g] <= res_val;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr < REG_AW'(NREG))
      cfg_rdata = mem_q[cfg_addr];
    else if (cfg_addr < REG_AW'(RES_BASE + NPTS))
      cfg_rdata = DW'(res_q[roff[PT_W-1:0]]);
  end

  always_comb begin
    cfg.pt_mask   = mem_q[W_MASK][NPTS-1:0];
    cfg.unit      = mem_q[W_UNIT][CW-1:0];
    cfg.sense     = mem_q[W_SENSE][CW-1:0];
    cfg.gap       = mem_q[W_GAP][CW-1:0];
    cfg.limit     = mem_q[W_LIMIT][CW-1:0];
    cfg.wctl      = mem_q[W_WCTL][NWR-1:0];
    cfg.sel_addr  = mem_q[W_SELA];
    cfg.mux_addr  = mem_q[W_MUXA];
    cfg.mux_val   = mem_q[W_MUXV];
    cfg.xa_addr   = mem_q[W_XAA];
    cfg.xa_val    = mem_q[W_XAV];
    cfg.xb_addr   = mem_q[W_XBA];
    cfg.xb_val    = mem_q[W_XBV];
    cfg.en_addr   = mem_q[W_ENA];
    cfg.en_val    = mem_q[W_ENV];
    cfg.vld_addr  = mem_q[W_VLDA];
    cfg.volt_addr = mem_q[W_VOLA];
    cfg.split     = |mem_q[W_SPLIT];
    cfg.vsel      = mem_q[W_VSEL][5:0];
    cfg.shift     = mem_q[W_SHIFT][4:0];
    for (int i = 0; i < NPTS; i++) cfg.sel_val[i] = mem_q[W_SELV + i];
  end
endmodule

// File: rtl/adcps_pacer.sv
module adcps_pacer
  import adcps_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] unit,
  input  logic [CW-1:0] sense,
  output logic          round_go
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CW-1:0]    ucnt_q, ucnt_d;
  logic [PRE_W-1:0] pre_lim;
  logic             run, tick;

  assign pre_lim  = {unit, 8'h00} - PRE_W'(1);
  assign run      = (unit != '0) && (sense != '0);
  assign tick     = run && (pre_q == pre_lim);
  assign round_go = tick && (ucnt_q == sense - CW'(1));

  always_comb begin
    pre_d  = pre_q;
    ucnt_d = ucnt_q;
    if (!run) begin
      pre_d  = '0;
      ucnt_d = '0;
    end else if (tick) begin
      pre_d  = '0;
      ucnt_d = round_go ? '0 : ucnt_q + CW'(1);
    end else begin
      pre_d  = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      ucnt_q <= '0;
    end else begin
      pre_q  <= pre_d;
      ucnt_q <= ucnt_d;
    end
  end
endmodule

// File: rtl/adcps_seq.sv
module adcps_seq
  import adcps_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_t             cfg,
  input  logic             round_go,
  output logic             m_req,
  output logic             m_we,
  output logic [AW-1:0]    m_addr,
  output logic [DW-1:0]    m_wdata,
  input  logic             m_ack,
  input  logic [DW-1:0]    m_rdata,
  output logic             res_we,
  output logic [PT_W-1:0]  res_idx,
  output logic [RES_W-1:0] res_val,
  output logic             timeout_evt
);
  seq_st_t          st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CW-1:0]    fail_q, fail_d, gap_q, gap_d;
  logic             tmo_q, tmo_d;
  logic             flag, ok;
  logic [DW-1:0]    word_sh;
  logic [PT_W-1:0]  pt;

  function automatic seq_st_t pick_wr(input logic [NWR-1:0] rem);
    if (rem[0])      return S_SEL;
    else if (rem[1]) return S_MUX;
    else if (rem[2]) return S_XA;
    else if (rem[3]) return S_XB;
    else             return S_EN;
  endfunction

  assign pt          = idx_q[PT_W-1:0];
  assign flag        = m_rdata[cfg.vsel[4:0]];
  assign ok          = cfg.vsel[5] ? flag : !flag;
  assign word_sh     = m_rdata >> cfg.shift;
  assign res_val     = word_sh[RES_W-1:0];
  assign res_idx     = pt;
  assign timeout_evt = tmo_q;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    fail_d = fail_q;
    gap_d  = gap_q;
    tmo_d  = 1'b0;
    res_we = 1'b0;
    case (st_q)
      S_IDLE: if (round_go) begin idx_d = '0; st_d = S_NEXT; end
      S_NEXT: begin
        if (idx_q == IDX_W'(NPTS)) st_d = S_IDLE;
        else if (cfg.pt_mask[pt]) begin
          st_d   = pick_wr(cfg.wctl);
          fail_d = '0;
        end else idx_d = idx_q + IDX_W'(1);
      end
      S_SEL: if (m_ack) st_d = pick_wr(cfg.wctl & 4'b1110);
      S_MUX: if (m_ack) st_d = pick_wr(cfg.wctl & 4'b1100);
      S_XA:  if (m_ack) st_d = pick_wr(cfg.wctl & 4'b1000);
      S_XB:  if (m_ack) st_d = S_EN;
      S_EN:  if (m_ack) st_d = S_POLL;
      S_POLL: if (m_ack) begin
        if (ok) begin
          if (cfg.split) st_d = S_VOLT;
          else begin
            res_we = 1'b1;
            idx_d  = idx_q + IDX_W'(1);
            st_d   = S_NEXT;
          end
        end else if (fail_q == cfg.limit) begin
          tmo_d = 1'b1;
          idx_d = idx_q + IDX_W'(1);
          st_d  = S_NEXT;
        end else begin
          fail_d = fail_q + CW'(1);
          gap_d  = '0;
          st_d   = S_GAP;
        end
      end
      S_GAP: begin
        if (gap_q == cfg.gap) st_d = S_POLL;
        else                  gap_d = gap_q + CW'(1);
      end
      S_VOLT: if (m_ack) begin
        res_we = 1'b1;
        idx_d  = idx_q + IDX_W'(1);
        st_d   = S_NEXT;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_comb begin
    m_req   = 1'b1;
    m_we    = 1'b1;
    m_addr  = '0;
    m_wdata = '0;
    case (st_q)
      S_SEL:  begin m_addr = cfg.sel_addr; m_wdata = cfg.sel_val[pt]; end
      S_MUX:  begin m_addr = cfg.mux_addr; m_wdata = cfg.mux_val;     end
      S_XA:   begin m_addr = cfg.xa_addr;  m_wdata = cfg.xa_val;      end
      S_XB:   begin m_addr = cfg.xb_addr;  m_wdata = cfg.xb_val;      end
      S_EN:   begin m_addr = cfg.en_addr;  m_wdata = cfg.en_val;      end
      S_POLL: begin m_we = 1'b0; m_addr = cfg.vld_addr;  end
      S_VOLT: begin m_we = 1'b0; m_addr = cfg.volt_addr; end
      default: begin m_req = 1'b0; m_we = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      fail_q <= '0;
      gap_q  <= '0;
      tmo_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      fail_q <= fail_d;
      gap_q  <= gap_d;
      tmo_q  <= tmo_d;
    end
  end
endmodule

// File: rtl/adc_poll_seq.sv
module adc_poll_seq
  import adcps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  output logic              m_req,
  output logic              m_we,
  output logic [AW-1:0]     m_addr,
  output logic [DW-1:0]     m_wdata,
  input  logic              m_ack,
  input  logic [DW-1:0]     m_rdata,
  output logic              timeout_evt
);
  logic [1:0]       rst_sync_q;
  logic             rst_s_n;
  cfg_t             cfg_s;
  logic             round_go;
  logic             res_we;
  logic [PT_W-1:0]  res_idx;
  logic [RES_W-1:0] res_val;

  // reset asserts at once, releases two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  adcps_regs u_regs (
    .clk(clk), .rst_n(rst_s_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .res_we(res_we),
    .res_idx(res_idx), .res_val(res_val), .cfg(cfg_s)
  );

  adcps_pacer u_pacer (
    .clk(clk), .rst_n(rst_s_n), .unit(cfg_s.unit), .sense(cfg_s.sense),
    .round_go(round_go)
  );

  adcps_seq u_seq (
    .clk(clk), .rst_n(rst_s_n), .cfg(cfg_s), .round_go(round_go),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_ack(m_ack), .m_rdata(m_rdata), .res_we(res_we), .res_idx(res_idx),
    .res_val(res_val), .timeout_evt(timeout_evt)
  );
endmodule

// File: rtl/adcps_chk.sv
module adcps_chk
  import adcps_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          m_req,
  input logic          m_we,
  input logic [AW-1:0] m_addr,
  input logic [DW-1:0] m_wdata,
  input logic          m_ack,
  input logic          timeout_evt,
  input cfg_t          cfg
);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ack) |=> (m_req && $stable(m_we) && $stable(m_addr) && $stable(m_wdata)));

  assert_rd_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_we) |-> (m_addr == cfg.vld_addr || m_addr == cfg.volt_addr));

  assert_wr_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_we) |-> (m_addr == cfg.sel_addr || m_addr == cfg.mux_addr ||
                         m_addr == cfg.xa_addr  || m_addr == cfg.xb_addr  ||
                         m_addr == cfg.en_addr));

  assert_volt_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_we && m_addr == cfg.volt_addr && m_addr != cfg.vld_addr) |-> cfg.split);

  assert_tmo_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> !timeout_evt);

  assert_tmo_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_evt) |-> $past(m_req && m_ack && !m_we));
endmodule

bind adc_poll_seq adcps_chk u_chk (
  .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
  .m_wdata(m_wdata), .m_ack(m_ack), .timeout_evt(timeout_evt), .cfg(cfg_s)
);

// File: tb/sim_adc_poll_seq.sv
module sim_adc_poll_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        m_req, m_we, m_ack, timeout_evt;
  logic [31:0] m_addr, m_wdata, m_rdata;

  adc_poll_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .m_req(m_req), .m_we(m_we),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_ack(m_ack), .m_rdata(m_rdata),
    .timeout_evt(timeout_evt)
  );

  always #4 clk = ~clk;

  localparam logic [31:0] A_SEL = 32'h1000_0010, A_MUX = 32'h1000_0020, V_MUX = 32'h0000_0800;
  localparam logic [31:0] A_XA = 32'h1000_0030, V_XA = 32'h0000_00A5, A_XB = 32'h1000_0034;
  localparam logic [31:0] V_XB = 32'h0000_005A, A_EN = 32'h2000_0008, V_EN = 32'h0000_0800;
  localparam logic [31:0] A_VLD = 32'h2000_0040, A_VOLT = 32'h2000_0044;

  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [31:0] data;
    bit          after_fail;
    string       req;
  } item_t;
  item_t q[$];

  int checks = 0, errors = 0, exp_gap = 0, low_cnt = 0, tmo_cnt = 0;
  int xfers = 0;
  longint cyc = 0;
  longint t_sel0[$];

  task automatic chk(input string r, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", r, what, got, exp);
    end
  endtask

  task automatic exp_wr(input logic [31:0] a, input logic [31:0] d, input string r);
    item_t it;
    it.we = 1; it.addr = a; it.data = d; it.after_fail = 0; it.req = r;
    q.push_back(it);
  endtask

  task automatic exp_rd(input logic [31:0] a, input logic [31:0] d, input bit af, input string r);
    item_t it;
    it.we = 0; it.addr = a; it.data = d; it.after_fail = af; it.req = r;
    q.push_back(it);
  endtask

  task automatic wr_cfg(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_cfg(input int a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = 5'(a);
    #1 d = cfg_rdata;
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 5000 && q.size() != 0; i++) @(negedge clk);
    repeat (6) @(negedge clk);
    chk("R3", "pending expected transactions", 32'(q.size()), 32'd0);
  endtask

  task automatic chk_res(input int pt, input logic [31:0] exp, input string r);
    logic [31:0] d;
    rd_cfg(24 + pt, d);
    chk(r, $sformatf("result of point %0d", pt), d, exp);
  endtask

  // monitor and target model: pops the scoreboard at each accepted transaction
  initial begin
    m_ack = 1'b0; m_rdata = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (timeout_evt) tmo_cnt++;
      if (!m_req) low_cnt++;
      if (m_ack) m_ack = 1'b0;
      else if (m_req && rst_n) begin
        item_t it;
        xfers++;
        if (q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R3 unexpected transaction: got addr %h we %0d expected none", m_addr, m_we);
          m_rdata = '0;
        end else begin
          it = q.pop_front();
          chk(it.req, "direction", 32'(m_we), 32'(it.we));
          chk(it.req, "address", m_addr, it.addr);
          if (it.we) chk(it.req, "write data", m_wdata, it.data);
          if (it.after_fail) chk("R7", "idle cycles between polls", 32'(low_cnt), 32'(exp_gap + 1));
          m_rdata = it.we ? 32'h0 : it.data;
        end
        if (m_we && m_addr == A_SEL && m_wdata == 32'h55) t_sel0.push_back(cyc);
        m_ack = 1'b1;
        low_cnt = 0;
      end
    end
  end

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "m_req after reset", 32'(m_req), 32'd0);
    chk("R1", "timeout after reset", 32'(timeout_evt), 32'd0);
    for (int p = 0; p < 4; p++) chk_res(p, 32'h0, "R1");

    // common addresses and values
    wr_cfg(6, A_SEL);  wr_cfg(7, A_MUX); wr_cfg(8, V_MUX);
    wr_cfg(9, A_XA);   wr_cfg(10, V_XA); wr_cfg(11, A_XB); wr_cfg(12, V_XB);
    wr_cfg(13, A_EN);  wr_cfg(14, V_EN); wr_cfg(15, A_VLD); wr_cfg(16, A_VOLT);
    wr_cfg(20, 32'h55); wr_cfg(21, 32'h66); wr_cfg(22, 32'h77); wr_cfg(23, 32'h99);

    // scenario A: points 0 and 2, all writes, shared word, flag bit 12 active-high
    wr_cfg(0, 32'h5); wr_cfg(5, 32'hF); wr_cfg(17, 0); wr_cfg(18, 32'h2C);
    wr_cfg(19, 0); wr_cfg(4, 3); wr_cfg(3, 1); exp_gap = 1;
    for (int r = 0; r < 2; r++) begin
      for (int p = 0; p < 4; p += 2) begin
        exp_wr(A_SEL, (p == 0) ? 32'h55 : 32'h77, "R3");
        exp_wr(A_MUX, V_MUX, "R3"); exp_wr(A_XA, V_XA, "R3");
        exp_wr(A_XB, V_XB, "R3");   exp_wr(A_EN, V_EN, "R3");
        if (r == 0 && p == 0) exp_rd(A_VLD, 32'h0000_1123, 0, "R4");
        if (r == 0 && p == 2) begin
          exp_rd(A_VLD, 32'h0000_0456, 0, "R4");
          exp_rd(A_VLD, 32'h0000_1456, 1, "R4");
        end
        if (r == 1 && p == 0) exp_rd(A_VLD, 32'h0000_1FFF, 0, "R4");
        if (r == 1 && p == 2) exp_rd(A_VLD, 32'hFFFF_1ABC, 0, "R4");
      end
    end
    wr_cfg(2, 2); wr_cfg(1, 1);
    wait_drain();
    wr_cfg(1, 0);
    chk("R2", "rounds observed", 32'(t_sel0.size()), 32'd2);
    if (t_sel0.size() >= 2) chk("R2", "round period", 32'(t_sel0[1] - t_sel0[0]), 32'd512);
    chk_res(0, 32'hFFF, "R6"); chk_res(1, 32'h0, "R3");
    chk_res(2, 32'hABC, "R6"); chk_res(3, 32'h0, "R3");

    // pacer stopped: nothing happens
    n0 = xfers;
    repeat (1200) @(negedge clk);
    chk("R2", "transactions while unit is zero", 32'(xfers - n0), 32'd0);

    // scenario B: points 1 and 3, start write only, split read, flag bit 3 active-low, shift 4
    wr_cfg(0, 32'hA); wr_cfg(5, 0); wr_cfg(17, 1); wr_cfg(18, 32'h03);
    wr_cfg(19, 4); wr_cfg(3, 0); exp_gap = 0;
    exp_wr(A_EN, V_EN, "R3");
    exp_rd(A_VLD, 32'hFFFF_FFF7, 0, "R4");
    exp_rd(A_VOLT, 32'h000A_BCD0, 0, "R5");
    exp_wr(A_EN, V_EN, "R3");
    exp_rd(A_VLD, 32'h0000_0008, 0, "R4");
    exp_rd(A_VLD, 32'h0000_0000, 1, "R4");
    exp_rd(A_VOLT, 32'h1234_5678, 0, "R5");
    wr_cfg(2, 1); wr_cfg(1, 1);
    wait_drain();
    wr_cfg(1, 0);
    chk_res(1, 32'hBCD, "R5"); chk_res(3, 32'h567, "R6");
    chk_res(0, 32'hFFF, "R3"); chk_res(2, 32'hABC, "R3");
    wr_cfg(25, 32'h0);
    chk_res(1, 32'hBCD, "R9");
    chk("R8", "timeouts so far", 32'(tmo_cnt), 32'd0);

    // scenario C: point 0 times out after three failed polls, point 1 still measured
    wr_cfg(0, 32'h3); wr_cfg(5, 1); wr_cfg(17, 0); wr_cfg(18, 32'h2C);
    wr_cfg(19, 0); wr_cfg(4, 2);
    exp_wr(A_SEL, 32'h55, "R3"); exp_wr(A_EN, V_EN, "R3");
    exp_rd(A_VLD, 32'h0, 0, "R8"); exp_rd(A_VLD, 32'h0, 1, "R8"); exp_rd(A_VLD, 32'h0, 1, "R8");
    exp_wr(A_SEL, 32'h66, "R8"); exp_wr(A_EN, V_EN, "R8");
    exp_rd(A_VLD, 32'h0000_1321, 0, "R8");
    wr_cfg(1, 1);
    wait_drain();
    wr_cfg(1, 0);
    chk("R8", "timeout pulses", 32'(tmo_cnt), 32'd1);
    chk_res(0, 32'hFFF, "R8"); chk_res(1, 32'h321, "R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule